// File: doc/BRIEF.md
# Class-Driven Instruction Expander

This block turns one compressed instruction of variable length back into a full 32-bit instruction word. The compressed form starts with a 4-bit class index. The class index selects one entry of a class table that software programs. That entry sets three things: how long the vocabulary pointer is, how wide the literal (bypass) field that carries the upper half-word is, and which of two vocabulary RAMs holds the lower half-word.

The caller presents a window that is left-aligned, so that its most significant bit is the first bit of the compressed instruction, and uses a valid/ready handshake. Once a window is accepted, the block issues one synchronous read to the selected vocabulary RAM. One cycle later it presents the rebuilt instruction, together with the number of window bits that were consumed, so that an upstream aligner can advance past them. A class entry that is not usable produces an error result in place of an instruction. The two RAMs share one address bus and have separate read enables.

Top module: `cls_unpack`

## Requirements
- R1: The class index is `in_win[31:28]`. Class entry k occupies `cls_tbl[k*31 +: 31]`, with the following fields: bit 0 marks the entry valid, bit 1 is the layout flag and must be 1, bits [5:2] give the pointer length, bits [9:6] give the width code, bit 10 selects the RAM, bits [20:11] give the RAM 1 base address, and bits [30:21] give the RAM 2 base address.
- R2: The pointer field follows the class index directly. It is as many bits long as the pointer length says, and its first bit is its most significant bit. Legal pointer lengths are 2 to 9.
- R3: The bypass field follows the pointer directly. Width code 11 gives a width of 0 bits, code 12 gives 10 bits, code 13 gives 15 bits and code 14 gives 16 bits. The field is zero-extended to form the upper half-word, so a width of 0 gives an upper half-word of zero.
- R4: When the RAM-select bit is 0, only RAM 1 is read, at base1 plus the pointer. When it is 1, only RAM 2 is read, at base2 plus the pointer. The sum wraps modulo 1024, and the two RAMs are never read in the same cycle.
- R5: The output instruction is the upper half-word in bits [31:16] and the vocabulary entry in bits [15:0].
- R6: `out_len` equals 4 plus the pointer length plus the bypass width.
- R7: `out_valid` is high in the cycle that directly follows a cycle in which `in_valid` and `in_ready` were both high.
- R8: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, the result stays valid and unchanged.
- R9: An entry is flagged as an error if any of these holds: its valid bit is clear, its layout flag is 0, its width code lies outside 11 to 14, or its pointer length lies outside 2 to 9. An error result comes out with `out_err`=1, `out_instr`=0 and `out_len`=0, and no RAM is read for it.
- R10: While reset is asserted and directly after it, `out_valid` is 0, `in_ready` is 1 and neither RAM is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A compressed window is offered |
| in_ready | output | 1 | The window is accepted this cycle |
| in_win | input | 32 | Compressed bits, left-aligned |
| cls_tbl | input | 496 | 16 class entries of 31 bits each |
| vram1_rd | output | 1 | Read enable for RAM 1 |
| vram2_rd | output | 1 | Read enable for RAM 2 |
| vram_addr | output | 10 | Read address shared by both RAMs |
| vram1_rdata | input | 16 | RAM 1 data, one cycle after the read |
| vram2_rdata | input | 16 | RAM 2 data, one cycle after the read |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result |
| out_instr | output | 32 | Rebuilt instruction |
| out_len | output | 6 | Number of compressed bits consumed |
| out_err | output | 1 | The class entry was unusable |

## Verification
Every result is due exactly one clock after the edge at which its window was accepted. The vocabulary read is issued in the same cycle as the acceptance, so the RAM data arrives together with the valid flag. The bench keeps a reference that advances on each rising edge using the same handshake inputs. At every falling edge it compares the valid flag, the ready flag, the error flag, the length and the instruction, so a result that arrives one cycle early or late is reported as a mismatch. Random stalls on `out_ready` check that a held result stays unchanged until the consumer takes it.

// File: rtl/cls_unpack_pkg.sv
package cls_unpack_pkg;

  localparam int CLS_W  = 4;
  localparam int PLEN_MIN = 2;
  localparam int PLEN_MAX = 9;

  typedef enum logic [3:0] {
    WC_NONE = 4'd11,
    WC_W10  = 4'd12,
    WC_W15  = 4'd13,
    WC_W16  = 4'd14
  } wcode_e;

  // bypass width selected by a width code (0 when illegal)
  function automatic logic [4:0] byp_width(input logic [3:0] code);
    case (code)
      WC_W10:  return 5'd10;
      WC_W15:  return 5'd15;
      WC_W16:  return 5'd16;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic code_legal(input logic [3:0] code);
    return (code >= WC_NONE) && (code <= WC_W16);
  endfunction

  function automatic logic plen_legal(input logic [3:0] plen);
    return (plen >= 4'(PLEN_MIN)) && (plen <= 4'(PLEN_MAX));
  endfunction

  function automatic logic [5:0] used_bits(input logic [3:0] plen,
                                           input logic [4:0] bw);
    return 6'(CLS_W) + 6'(plen) + 6'(bw);
  endfunction

endpackage

// File: rtl/cls_field_dec.sv
module cls_field_dec
  import cls_unpack_pkg::*;
#(
  parameter int WIN_W  = 32,
  parameter int ADDR_W = 10,
  localparam int NCLS   = 1 << CLS_W,
  localparam int DESC_W = 11 + 2 * ADDR_W
) (
  input  logic [WIN_W-1:0]       win,
  input  logic [NCLS*DESC_W-1:0] tbl,
  output logic                   dec_err,
  output logic                   dec_sel,
  output logic [ADDR_W-1:0]      dec_addr,
  output logic [15:0]            dec_upper,
  output logic [5:0]             dec_len
);

  logic [CLS_W-1:0]  cls;
  logic [DESC_W-1:0] desc;
  logic              d_valid, d_ds;
  logic [3:0]        d_plen, d_code;
  logic [ADDR_W-1:0] d_base1, d_base2;
  logic [4:0]        bw;
  logic [WIN_W-1:0]  after_cls, after_ptr, ptr_full, byp_full;

  assign cls     = win[WIN_W-1 -: CLS_W];
  assign desc    = tbl[cls*DESC_W +: DESC_W];
  assign d_valid = desc[0];
  assign d_ds    = desc[1];
  assign d_plen  = desc[5:2];
  assign d_code  = desc[9:6];
  assign dec_sel = desc[10];
  assign d_base1 = desc[11 +: ADDR_W];
  assign d_base2 = desc[11+ADDR_W +: ADDR_W];
  assign bw      = byp_width(d_code);

  // fields are consumed from the top of the window downward
  always_comb begin
    after_cls = win << CLS_W;
    ptr_full  = after_cls >> (WIN_W - int'(d_plen));
    after_ptr = after_cls << d_plen;
    byp_full  = (bw == 5'd0) ? '0 : (after_ptr >> (WIN_W - int'(bw)));
  end

  assign dec_upper = byp_full[15:0];
  assign dec_addr  = (dec_sel ? d_base2 : d_base1) + ptr_full[ADDR_W-1:0];
  assign dec_len   = used_bits(d_plen, bw);
  assign dec_err   = !d_valid || !d_ds || !code_legal(d_code) || !plen_legal(d_plen);

endmodule

// File: rtl/cls_read_stage.sv
module cls_read_stage #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              dec_err,
  input  logic              dec_sel,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [15:0]       dec_upper,
  input  logic [5:0]        dec_len,
  input  logic              out_ready,
  input  logic [15:0]       rdata1,
  input  logic [15:0]       rdata2,
  output logic              rd1,
  output logic              rd2,
  output logic [ADDR_W-1:0] raddr,
  output logic              out_valid,
  output logic              out_err,
  output logic [31:0]       out_instr,
  output logic [5:0]        out_len
);

  logic              v_q, err_q, sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       up_q;
  logic [5:0]        len_q;
  logic              stall;

  assign stall = v_q && !out_ready;

  // a stalled result re-reads its word so the RAM output stays put
  always_comb begin
    if (accept) begin
      rd1   = !dec_err && !dec_sel;
      rd2   = !dec_err &&  dec_sel;
      raddr = dec_addr;
    end else begin
      rd1   = stall && !err_q && !sel_q;
      rd2   = stall && !err_q &&  sel_q;
      raddr = addr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      err_q  <= 1'b0;
      sel_q  <= 1'b0;
      addr_q <= '0;
      up_q   <= '0;
      len_q  <= '0;
    end else if (accept) begin
      v_q    <= 1'b1;
      err_q  <= dec_err;
      sel_q  <= dec_sel;
      addr_q <= dec_addr;
      up_q   <= dec_upper;
      len_q  <= dec_len;
    end else if (v_q && out_ready) begin
      v_q    <= 1'b0;
    end
  end

  assign out_valid = v_q;
  assign out_err   = v_q && err_q;
  assign out_len   = (v_q && !err_q) ? len_q : 6'd0;
  assign out_instr = (v_q && !err_q) ? {up_q, (sel_q ? rdata2 : rdata1)} : 32'd0;

  p_one_ram_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd1, rd2}));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_len) && $stable(out_err)));

  p_err_noread_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec_err) |-> (!rd1 && !rd2));

endmodule

// File: rtl/cls_unpack.sv
module cls_unpack
  import cls_unpack_pkg::*;
#(
  parameter int WIN_W  = 32,
  parameter int ADDR_W = 10,
  localparam int NCLS   = 1 << CLS_W,
  localparam int DESC_W = 11 + 2 * ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WIN_W-1:0]       in_win,
  input  logic [NCLS*DESC_W-1:0] cls_tbl,
  output logic                   vram1_rd,
  output logic                   vram2_rd,
  output logic [ADDR_W-1:0]      vram_addr,
  input  logic [15:0]            vram1_rdata,
  input  logic [15:0]            vram2_rdata,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [31:0]            out_instr,
  output logic [5:0]             out_len,
  output logic                   out_err
);

  logic              accept;
  logic              dec_err, dec_sel;
  logic [ADDR_W-1:0] dec_addr;
  logic [15:0]       dec_upper;
  logic [5:0]        dec_len;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  cls_field_dec #(.WIN_W(WIN_W), .ADDR_W(ADDR_W)) u_dec (
    .win       (in_win),
    .tbl       (cls_tbl),
    .dec_err   (dec_err),
    .dec_sel   (dec_sel),
    .dec_addr  (dec_addr),
    .dec_upper (dec_upper),
    .dec_len   (dec_len)
  );

  cls_read_stage #(.ADDR_W(ADDR_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .dec_err   (dec_err),
    .dec_sel   (dec_sel),
    .dec_addr  (dec_addr),
    .dec_upper (dec_upper),
    .dec_len   (dec_len),
    .out_ready (out_ready),
    .rdata1    (vram1_rdata),
    .rdata2    (vram2_rdata),
    .rd1       (vram1_rd),
    .rd2       (vram2_rd),
    .raddr     (vram_addr),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_instr (out_instr),
    .out_len   (out_len)
  );

  p_len_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> (out_len >= 6'd6 && out_len <= 6'd29));

  p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/cls_unpack_bench.sv
`timescale 1ns/1ps
module cls_unpack_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_win = '0;
  logic [495:0] cls_tbl;
  logic        vram1_rd, vram2_rd;
  logic [9:0]  vram_addr;
  logic [15:0] q1 = '0, q2 = '0;
  logic        out_valid, out_ready = 1'b1, out_err;
  logic [31:0] out_instr;
  logic [5:0]  out_len;

  always #5 clk = ~clk;

  cls_unpack u_cls_unpack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_win(in_win), .cls_tbl(cls_tbl), .vram1_rd(vram1_rd), .vram2_rd(vram2_rd),
    .vram_addr(vram_addr), .vram1_rdata(q1), .vram2_rdata(q2),
    .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
    .out_len(out_len), .out_err(out_err)
  );

  function automatic logic [15:0] word1(input int a);
    return 16'((a * 40503 + 4660) & 16'hFFFF);
  endfunction
  function automatic logic [15:0] word2(input int a);
    return 16'(((a * 32587) ^ 48879) & 16'hFFFF);
  endfunction

  // synchronous vocabulary memories
  always @(posedge clk) begin
    if (vram1_rd) q1 <= word1(int'(vram_addr));
    if (vram2_rd) q2 <= word2(int'(vram_addr));
  end

  // class table, kept as separate bench arrays
  int t_val[16], t_ds[16], t_pl[16], t_code[16], t_sel[16], t_b1[16], t_b2[16];

  task automatic set_cls(input int k, input int v, input int ds, input int pl,
                         input int code, input int sel, input int b1, input int b2);
    t_val[k] = v; t_ds[k] = ds; t_pl[k] = pl; t_code[k] = code;
    t_sel[k] = sel; t_b1[k] = b1; t_b2[k] = b2;
    cls_tbl[k*31 + 0]       = 1'(v);
    cls_tbl[k*31 + 1]       = 1'(ds);
    cls_tbl[k*31 + 2 +: 4]  = 4'(pl);
    cls_tbl[k*31 + 6 +: 4]  = 4'(code);
    cls_tbl[k*31 + 10]      = 1'(sel);
    cls_tbl[k*31 + 11 +: 10] = 10'(b1);
    cls_tbl[k*31 + 21 +: 10] = 10'(b2);
  endtask

  // reference model state
  bit          m_v = 0, m_err = 0, last_acc = 0;
  logic [31:0] m_instr = '0;
  int          m_len = 0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  task automatic model_take(input logic [31:0] w);
    int k, bw, pos, ptr, byp, a;
    k = int'(w[31:28]);
    case (t_code[k]) 11: bw = 0; 12: bw = 10; 13: bw = 15; 14: bw = 16; default: bw = -1; endcase
    m_err = (t_val[k] == 0) || (t_ds[k] == 0) || (bw < 0) || (t_pl[k] < 2) || (t_pl[k] > 9);
    if (m_err) begin
      m_instr = 0; m_len = 0;
    end else begin
      pos = 27; ptr = 0; byp = 0;
      for (int i = 0; i < t_pl[k]; i++) begin ptr = ptr * 2 + int'(w[pos]); pos--; end
      for (int i = 0; i < bw; i++) begin byp = byp * 2 + int'(w[pos]); pos--; end
      a = ((t_sel[k] != 0 ? t_b2[k] : t_b1[k]) + ptr) % 1024;
      m_instr = {16'(byp), (t_sel[k] != 0) ? word2(a) : word1(a)};
      m_len = 4 + t_pl[k] + bw;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_v = 0; last_acc = 0;
    end else begin
      last_acc = in_valid && (!m_v || out_ready);
      if (last_acc) begin model_take(in_win); m_v = 1; end
      else if (m_v && out_ready) m_v = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == m_v, "R7 out_valid", out_valid, m_v);
      chk(in_ready == (!m_v || out_ready), "R8 in_ready", in_ready, !m_v || out_ready);
      chk(!(vram1_rd && vram2_rd), "R4 single RAM read", {vram1_rd, vram2_rd}, 0);
      if (m_v) begin
        chk(out_err == m_err, "R9 out_err", out_err, m_err);
        chk(int'(out_len) == m_len, "R6 out_len", out_len, m_len);
        chk(out_instr == m_instr, "R1 R2 R3 R4 R5 out_instr", out_instr, m_instr);
      end
    end
  end

  task automatic send(input logic [31:0] w);
    in_valid = 1'b1; in_win = w;
    do @(negedge clk); while (!last_acc);
    #1;
    in_valid = 1'b0;
  endtask

  bit rnd_ready = 0;
  always @(negedge clk) begin
    #1;
    out_ready = rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cls_tbl = '0;
    set_cls(0, 1, 1, 2, 11, 0, 100, 0);
    set_cls(1, 1, 1, 9, 14, 1, 0, 1000);   // wraps in RAM 2
    set_cls(2, 1, 1, 5, 12, 0, 7, 0);
    set_cls(3, 1, 1, 7, 13, 1, 0, 300);
    set_cls(4, 0, 1, 4, 12, 0, 0, 0);      // R9 invalid entry
    set_cls(5, 1, 1, 4, 10, 0, 0, 0);      // R9 bad code
    set_cls(6, 1, 0, 4, 12, 0, 0, 0);      // R9 layout flag 0
    set_cls(7, 1, 1, 1, 12, 0, 0, 0);      // R9 pointer too short
    set_cls(8, 1, 1, 10, 11, 0, 0, 0);     // R9 pointer too long
    set_cls(9, 1, 1, 3, 14, 0, 1020, 0);   // wraps in RAM 1
    set_cls(10, 1, 1, 9, 12, 1, 0, 0);
    set_cls(11, 1, 1, 4, 15, 1, 0, 0);     // R9 bad code
    set_cls(12, 1, 1, 4, 13, 0, 512, 5);
    set_cls(13, 1, 1, 6, 14, 1, 9, 700);
    set_cls(14, 1, 1, 8, 11, 1, 3, 40);
    set_cls(15, 1, 1, 2, 12, 0, 1023, 2);

    // R10 reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R10 in_ready in reset", in_ready, 1);
    chk(!vram1_rd && !vram2_rd, "R10 no read in reset", {vram1_rd, vram2_rd}, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 out_valid after reset", out_valid, 0);
    #1;

    // directed: R2 R3 field order, zero bypass, full bypass, wraps
    send(32'h0FFF_FFFF);
    send(32'h1FFF_FFFF);
    send(32'h1000_0000);
    send(32'h9E00_0000);
    send(32'h2ABC_DEF0);
    send(32'h3123_4567);
    for (int k = 4; k < 9; k++) send({4'(k), 28'h5A5_A5A5});
    send(32'hB000_0000);
    repeat (3) @(negedge clk);
    #1;

    // back-to-back random windows
    for (int i = 0; i < 400; i++) send($urandom);
    // random back-pressure (R8)
    rnd_ready = 1;
    for (int i = 0; i < 600; i++) send($urandom);
    rnd_ready = 0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule